// File: doc/BRIEF.md
# Coprocessor Instruction Dispatch Interlock

The interlock sits between an in-order host pipeline and an attached coprocessor. The host hands it decoded extension instructions. Each one carries a two-bit class that sets how long the host has to wait for it. The interlock forwards each legal instruction to the coprocessor over a valid/ready handshake. It allows one instruction in flight at a time. A `host_stall` line tells the host when it must stop.

A "fire and forget" (autonomous) instruction frees the host as soon as the coprocessor accepts it. A later coprocessor instruction still waits until the earlier one is done. A blocking instruction holds the host until the coprocessor reports completion. After that, the result, the destination register and an overflow flag appear on a write-back port. A non-blocking instruction lets the host run on. The host stalls only when it reads the destination register while the result is still outstanding.

Static control fields gate the whole unit:
- unit enable,
- exception enable,
- floating-point coprocessor present,
- a two-bit floating-point exception mode.

When the unit is off, or an instruction carries the reserved class, the instruction is consumed and flagged illegal, and it is not dispatched.

Top module: `cxi_interlock`

## Requirements
- R1: While `ctl_unit_on` is 0, `cop_valid` stays 0. Any `ins_valid` instruction raises `illegal` and `ins_taken` in the same cycle, and `host_stall` stays 0.
- R2: Class code 2'b11 is reserved. With the unit on, such an instruction raises `illegal` and `ins_taken` in the same cycle and never raises `cop_valid`.
- R3: Class codes are 2'b00 autonomous, 2'b01 blocking and 2'b10 non-blocking. When an instruction with one of these classes is presented, the unit is on, nothing is outstanding and no precise-exception hold is active, `cop_valid` rises in the same cycle. In that cycle `cop_data` equals `ins_opnd` and `cop_kind` equals `ins_class`. `ins_taken` equals `cop_ready`, and `host_stall` is 1 while the instruction is not taken.
- R4: Only one instruction is outstanding. From the cycle after a handshake through the cycle in which `cop_done` is seen, `cop_valid` stays 0 and a waiting instruction stalls the host. A `cop_done` pulse while nothing is outstanding is ignored: it produces no write-back and no exception report.
- R5: An accepted autonomous instruction never raises `host_stall` by itself, whatever register the host reads, and its completion produces no write-back.
- R6: After a blocking instruction is accepted, `host_stall` is 1 from the next cycle through the `cop_done` cycle. In the cycle after `cop_done`, `host_stall` is 0 and `wb_valid` is 1 for one cycle, with `wb_data`, `wb_ovf` and `wb_reg` carrying the coprocessor result, its overflow flag and the instruction's destination.
- R7: While a non-blocking instruction is outstanding, including its `cop_done` cycle, `host_stall` is 1 only when `host_src_valid` is 1 and `host_src_reg` equals its destination. Its write-back follows one cycle after `cop_done`, as in R6.
- R8: `ctl_fe_mode` is {FE0,FE1}: 2'b00 ignore, 2'b10 imprecise recoverable, 2'b01 imprecise non-recoverable, 2'b11 precise. A `cop_exc` seen with `cop_done` gives a one-cycle `exc_report` in the next cycle only if `ctl_exc_en` is 1 and the effective mode is not ignore. With the report, `exc_recov` is 0 only for the non-recoverable mode.
- R9: When a report is made in precise mode, `host_stall` is 1 and `cop_valid` is 0 during the report cycle. Dispatch resumes in the cycle after.
- R10: With `ctl_fpu_here` at 0, the exception mode field is disregarded and exceptions are handled as precise.
- R11: During and right after reset, with no input active, `host_stall`, `cop_valid`, `wb_valid` and `exc_report` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_unit_on | input | 1 | Coprocessor unit enable |
| ctl_exc_en | input | 1 | Coprocessor exception enable |
| ctl_fpu_here | input | 1 | Floating-point coprocessor present |
| ctl_fe_mode | input | 2 | Exception mode {FE0,FE1} |
| ins_valid | input | 1 | Extension instruction presented by host |
| ins_class | input | 2 | Instruction class code |
| ins_dst | input | RW | Destination register for returned data |
| ins_opnd | input | DW | Operand forwarded to the coprocessor |
| ins_taken | output | 1 | Instruction consumed this cycle |
| illegal | output | 1 | Illegal-instruction exception pulse |
| host_stall | output | 1 | Hold the host pipeline |
| host_src_valid | input | 1 | Host reads a register this cycle |
| host_src_reg | input | RW | Register the host reads |
| cop_valid | output | 1 | Instruction offered to coprocessor |
| cop_ready | input | 1 | Coprocessor accepts the offer |
| cop_kind | output | 2 | Class of offered instruction |
| cop_data | output | DW | Operand of offered instruction |
| cop_done | input | 1 | Coprocessor completion pulse |
| cop_result | input | DW | Result, valid with cop_done |
| cop_ovf | input | 1 | Overflow status, valid with cop_done |
| cop_exc | input | 1 | Exception raised, valid with cop_done |
| wb_valid | output | 1 | Write-back strobe |
| wb_reg | output | RW | Write-back destination |
| wb_data | output | DW | Write-back data |
| wb_ovf | output | 1 | Write-back overflow flag |
| exc_report | output | 1 | Coprocessor exception report pulse |
| exc_recov | output | 1 | Reported exception is recoverable |

## Verification
The bench targets these corner cases:
- A second instruction presented while one is outstanding. A design that tracked more than one would offer it early.
- A stray `cop_done` while idle. A design that did not qualify completion would emit a phantom write-back or report.
- A non-blocking instruction checked against both a matching and a non-matching source register. A wrong compare either freezes the host needlessly or lets it read a stale value.
- All four exception modes, each with exceptions disabled and with the floating-point unit absent. This catches a swapped FE0/FE1 decode, a missing gate, or a precise hold that fails to block the next dispatch.

// File: rtl/cxi_pkg.sv
package cxi_pkg;

  localparam logic [1:0] CLS_AUTO = 2'b00;
  localparam logic [1:0] CLS_BLK  = 2'b01;
  localparam logic [1:0] CLS_NBLK = 2'b10;
  localparam logic [1:0] CLS_RSVD = 2'b11;

  localparam logic [1:0] FEM_IGNORE  = 2'b00;
  localparam logic [1:0] FEM_NONREC  = 2'b01;
  localparam logic [1:0] FEM_RECOV   = 2'b10;
  localparam logic [1:0] FEM_PRECISE = 2'b11;

  function automatic logic cls_legal(input logic [1:0] c);
    return c != CLS_RSVD;
  endfunction

  function automatic logic cls_returns(input logic [1:0] c);
    return (c == CLS_BLK) || (c == CLS_NBLK);
  endfunction

  // Without a floating-point unit every coprocessor exception is precise.
  function automatic logic [1:0] eff_mode(input logic fpu, input logic [1:0] fe);
    return fpu ? fe : FEM_PRECISE;
  endfunction

  function automatic logic exc_live(input logic en, input logic [1:0] m, input logic raised);
    return raised && en && (m != FEM_IGNORE);
  endfunction

  function automatic logic mode_recoverable(input logic [1:0] m);
    return m != FEM_NONREC;
  endfunction

endpackage

// File: rtl/cxi_issue.sv
module cxi_issue
  import cxi_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [1:0]    ins_class,
  input  logic [RW-1:0] ins_dst,
  input  logic          unit_on,
  input  logic          hold,
  input  logic          cop_ready,
  input  logic          cop_done,
  output logic          cop_valid,
  output logic          ins_taken,
  output logic          illegal,
  output logic          fire,
  output logic          retire,
  output logic          busy,
  output logic [1:0]    pend_cls,
  output logic [RW-1:0] pend_dst
);

  logic legal;

  always_comb begin
    legal     = cls_legal(ins_class);
    illegal   = ins_valid && (!unit_on || !legal);
    cop_valid = ins_valid && unit_on && legal && !busy && !hold;
    fire      = cop_valid && cop_ready;
    ins_taken = fire || illegal;
    retire    = cop_done && busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pend_cls <= CLS_AUTO;
      pend_dst <= '0;
    end else if (fire) begin
      busy     <= 1'b1;
      pend_cls <= ins_class;
      pend_dst <= ins_dst;
    end else if (retire) begin
      busy     <= 1'b0;
    end
  end

endmodule

// File: rtl/cxi_retire.sv
module cxi_retire
  import cxi_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retire,
  input  logic [1:0]    pend_cls,
  input  logic [RW-1:0] pend_dst,
  input  logic [DW-1:0] cop_result,
  input  logic          cop_ovf,
  input  logic          cop_exc,
  input  logic          exc_en,
  input  logic          fpu_here,
  input  logic [1:0]    fe_mode,
  output logic          wb_valid,
  output logic [RW-1:0] wb_reg,
  output logic [DW-1:0] wb_data,
  output logic          wb_ovf,
  output logic          exc_report,
  output logic          exc_recov,
  output logic          exc_hold
);

  logic [1:0] mode;
  logic       wb_evt;
  logic       exc_evt;

  always_comb begin
    mode    = eff_mode(fpu_here, fe_mode);
    wb_evt  = retire && cls_returns(pend_cls);
    exc_evt = retire && exc_live(exc_en, mode, cop_exc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid   <= 1'b0;
      wb_reg     <= '0;
      wb_data    <= '0;
      wb_ovf     <= 1'b0;
      exc_report <= 1'b0;
      exc_recov  <= 1'b0;
      exc_hold   <= 1'b0;
    end else begin
      wb_valid   <= wb_evt;
      exc_report <= exc_evt;
      exc_hold   <= exc_evt && (mode == FEM_PRECISE);
      if (wb_evt) begin
        wb_reg  <= pend_dst;
        wb_data <= cop_result;
        wb_ovf  <= cop_ovf;
      end
      if (exc_evt) exc_recov <= mode_recoverable(mode);
    end
  end

endmodule

// File: rtl/cxi_stall.sv
module cxi_stall
  import cxi_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          ins_valid,
  input  logic          ins_taken,
  input  logic          busy,
  input  logic [1:0]    pend_cls,
  input  logic [RW-1:0] pend_dst,
  input  logic          host_src_valid,
  input  logic [RW-1:0] host_src_reg,
  input  logic          exc_hold,
  output logic          blk_wait,
  output logic          dep_stall,
  output logic          host_stall
);

  logic nb_pend;
  logic issue_wait;

  always_comb begin
    blk_wait   = busy && (pend_cls == CLS_BLK);
    nb_pend    = busy && (pend_cls == CLS_NBLK);
    dep_stall  = nb_pend && host_src_valid && (host_src_reg == pend_dst);
    issue_wait = ins_valid && !ins_taken;
    host_stall = issue_wait || blk_wait || dep_stall || exc_hold;
  end

endmodule

// File: rtl/cxi_interlock.sv
module cxi_interlock
  import cxi_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_unit_on,
  input  logic          ctl_exc_en,
  input  logic          ctl_fpu_here,
  input  logic [1:0]    ctl_fe_mode,
  input  logic          ins_valid,
  input  logic [1:0]    ins_class,
  input  logic [RW-1:0] ins_dst,
  input  logic [DW-1:0] ins_opnd,
  output logic          ins_taken,
  output logic          illegal,
  output logic          host_stall,
  input  logic          host_src_valid,
  input  logic [RW-1:0] host_src_reg,
  output logic          cop_valid,
  input  logic          cop_ready,
  output logic [1:0]    cop_kind,
  output logic [DW-1:0] cop_data,
  input  logic          cop_done,
  input  logic [DW-1:0] cop_result,
  input  logic          cop_ovf,
  input  logic          cop_exc,
  output logic          wb_valid,
  output logic [RW-1:0] wb_reg,
  output logic [DW-1:0] wb_data,
  output logic          wb_ovf,
  output logic          exc_report,
  output logic          exc_recov
);

  // Internal events, named so the checker can observe them.
  logic          fire;
  logic          retire;
  logic          busy;
  logic [1:0]    pend_cls;
  logic [RW-1:0] pend_dst;
  logic          exc_hold;
  logic          blk_wait;
  logic          dep_stall;

  assign cop_kind = ins_class;
  assign cop_data = ins_opnd;

  cxi_issue #(.RW(RW)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .ins_class (ins_class),
    .ins_dst   (ins_dst),
    .unit_on   (ctl_unit_on),
    .hold      (exc_hold),
    .cop_ready (cop_ready),
    .cop_done  (cop_done),
    .cop_valid (cop_valid),
    .ins_taken (ins_taken),
    .illegal   (illegal),
    .fire      (fire),
    .retire    (retire),
    .busy      (busy),
    .pend_cls  (pend_cls),
    .pend_dst  (pend_dst)
  );

  cxi_retire #(.DW(DW), .RW(RW)) u_retire (
    .clk        (clk),
    .rst_n      (rst_n),
    .retire     (retire),
    .pend_cls   (pend_cls),
    .pend_dst   (pend_dst),
    .cop_result (cop_result),
    .cop_ovf    (cop_ovf),
    .cop_exc    (cop_exc),
    .exc_en     (ctl_exc_en),
    .fpu_here   (ctl_fpu_here),
    .fe_mode    (ctl_fe_mode),
    .wb_valid   (wb_valid),
    .wb_reg     (wb_reg),
    .wb_data    (wb_data),
    .wb_ovf     (wb_ovf),
    .exc_report (exc_report),
    .exc_recov  (exc_recov),
    .exc_hold   (exc_hold)
  );

  cxi_stall #(.RW(RW)) u_stall (
    .ins_valid      (ins_valid),
    .ins_taken      (ins_taken),
    .busy           (busy),
    .pend_cls       (pend_cls),
    .pend_dst       (pend_dst),
    .host_src_valid (host_src_valid),
    .host_src_reg   (host_src_reg),
    .exc_hold       (exc_hold),
    .blk_wait       (blk_wait),
    .dep_stall      (dep_stall),
    .host_stall     (host_stall)
  );

endmodule

// File: rtl/cxi_chk.sv
module cxi_chk
  import cxi_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_unit_on,
  input logic       ctl_exc_en,
  input logic       ins_valid,
  input logic [1:0] ins_class,
  input logic       illegal,
  input logic       cop_valid,
  input logic       cop_exc,
  input logic       busy,
  input logic [1:0] pend_cls,
  input logic       fire,
  input logic       retire,
  input logic       host_stall,
  input logic       blk_wait,
  input logic       exc_hold,
  input logic       wb_valid,
  input logic       exc_report
);

  p_off_no_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_unit_on |-> !cop_valid);

  p_rsvd_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_class == CLS_RSVD) |-> (illegal && !cop_valid));

  p_single_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cop_valid);

  p_busy_after_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> busy);

  p_auto_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pend_cls == CLS_AUTO && !ins_valid && !exc_hold) |-> !host_stall);

  p_block_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_wait |-> host_stall);

  p_wb_follows_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(retire));

  p_report_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_report |-> $past(retire && cop_exc && ctl_exc_en));

  p_precise_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_hold |-> (host_stall && !cop_valid && exc_report));

endmodule

bind cxi_interlock cxi_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_unit_on (ctl_unit_on),
  .ctl_exc_en  (ctl_exc_en),
  .ins_valid   (ins_valid),
  .ins_class   (ins_class),
  .illegal     (illegal),
  .cop_valid   (cop_valid),
  .cop_exc     (cop_exc),
  .busy        (busy),
  .pend_cls    (pend_cls),
  .fire        (fire),
  .retire      (retire),
  .host_stall  (host_stall),
  .blk_wait    (blk_wait),
  .exc_hold    (exc_hold),
  .wb_valid    (wb_valid),
  .exc_report  (exc_report)
);

// File: tb/sim_cxi_interlock.sv
`timescale 1ns/1ps
module sim_cxi_interlock;

  localparam int DW = 32;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctl_unit_on, ctl_exc_en, ctl_fpu_here;
  logic [1:0]    ctl_fe_mode;
  logic          ins_valid;
  logic [1:0]    ins_class;
  logic [RW-1:0] ins_dst;
  logic [DW-1:0] ins_opnd;
  logic          ins_taken, illegal, host_stall;
  logic          host_src_valid;
  logic [RW-1:0] host_src_reg;
  logic          cop_valid, cop_ready;
  logic [1:0]    cop_kind;
  logic [DW-1:0] cop_data;
  logic          cop_done;
  logic [DW-1:0] cop_result;
  logic          cop_ovf, cop_exc;
  logic          wb_valid;
  logic [RW-1:0] wb_reg;
  logic [DW-1:0] wb_data;
  logic          wb_ovf, exc_report, exc_recov;

  int n_run = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cxi_interlock #(.DW(DW), .RW(RW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected exception behaviour, from R8 and R10.
  function automatic bit b_rep(input bit raised);
    if (!raised || !ctl_exc_en) return 1'b0;
    if (!ctl_fpu_here) return 1'b1;
    return ctl_fe_mode != 2'b00;
  endfunction

  function automatic bit b_recov();
    if (!ctl_fpu_here) return 1'b1;
    return !(ctl_fe_mode[1] == 1'b0 && ctl_fe_mode[0] == 1'b1);
  endfunction

  function automatic bit b_hold(input bit raised);
    return b_rep(raised) && (!ctl_fpu_here || ctl_fe_mode == 2'b11);
  endfunction

  function automatic string cls_req(input logic [1:0] c);
    return (c == 2'b01) ? "R6" : ((c == 2'b10) ? "R7" : "R5");
  endfunction

  task automatic run_op(input logic [1:0] cls, input logic [RW-1:0] dst,
                        input logic [DW-1:0] opnd, input logic [DW-1:0] res,
                        input logic ovf, input logic exc, input int lat,
                        input int rw, input logic srcv, input logic [RW-1:0] src);
    bit exp_st;
    bit rep;
    @(negedge clk);
    ins_valid = 1'b1; ins_class = cls; ins_dst = dst; ins_opnd = opnd; cop_ready = 1'b0;
    for (int i = 0; i < rw; i++) begin
      #1;
      chk(cop_valid && !ins_taken && host_stall, "R3", "offer without ready",
          {cop_valid, ins_taken, host_stall}, 3'b101);
      @(negedge clk);
    end
    cop_ready = 1'b1;
    #1;
    chk(cop_valid && ins_taken && cop_data == opnd && cop_kind == cls && !host_stall,
        "R3", "handshake", {cop_valid, ins_taken, cop_kind, cop_data}, {2'b11, cls, opnd});
    @(negedge clk);
    ins_valid = 1'b0; cop_ready = 1'b0; host_src_valid = srcv; host_src_reg = src;
    exp_st = (cls == 2'b01) || (cls == 2'b10 && srcv && src == dst);
    for (int i = 0; i < lat; i++) begin
      #1;
      chk(host_stall == exp_st, cls_req(cls), "stall while outstanding", host_stall, exp_st);
      @(negedge clk);
    end
    cop_done = 1'b1; cop_result = res; cop_ovf = ovf; cop_exc = exc;
    #1;
    chk(host_stall == exp_st, cls_req(cls), "stall in done cycle", host_stall, exp_st);
    @(negedge clk);
    cop_done = 1'b0; cop_exc = 1'b0; host_src_valid = 1'b0;
    #1;
    chk(wb_valid == (cls != 2'b00), cls_req(cls), "write-back strobe", wb_valid, cls != 2'b00);
    if (cls != 2'b00)
      chk(wb_data == res && wb_reg == dst && wb_ovf == ovf, cls_req(cls), "write-back payload",
          {wb_ovf, wb_reg, wb_data}, {ovf, dst, res});
    rep = b_rep(exc);
    chk(exc_report == rep, "R8", "exception report", exc_report, rep);
    if (rep) chk(exc_recov == b_recov(), "R8", "recoverable flag", exc_recov, b_recov());
    chk(host_stall == b_hold(exc), ctl_fpu_here ? "R9" : "R10", "precise hold",
        host_stall, b_hold(exc));
  endtask

  initial begin
    int lim = 150000;
    repeat (lim) @(posedge clk);
    n_run++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", lim);
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h0C0FFEE5));
    rst_n = 1'b0; ctl_unit_on = 1'b1; ctl_exc_en = 1'b0; ctl_fpu_here = 1'b1;
    ctl_fe_mode = 2'b00; ins_valid = 1'b0; ins_class = 2'b00; ins_dst = '0;
    ins_opnd = '0; host_src_valid = 1'b0; host_src_reg = '0; cop_ready = 1'b0;
    cop_done = 1'b0; cop_result = '0; cop_ovf = 1'b0; cop_exc = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!host_stall && !cop_valid && !wb_valid && !exc_report, "R11", "in reset",
        {host_stall, cop_valid, wb_valid, exc_report}, 4'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!host_stall && !cop_valid && !wb_valid && !exc_report, "R11", "after reset",
        {host_stall, cop_valid, wb_valid, exc_report}, 4'b0);

    // R1: unit off
    @(negedge clk);
    ctl_unit_on = 1'b0; ins_valid = 1'b1; ins_class = 2'b01; cop_ready = 1'b1;
    #1;
    chk(!cop_valid && illegal && ins_taken && !host_stall, "R1", "unit off",
        {cop_valid, illegal, ins_taken, host_stall}, 4'b0110);
    // R2: reserved class with unit on
    @(negedge clk);
    ctl_unit_on = 1'b1; ins_class = 2'b11;
    #1;
    chk(!cop_valid && illegal && ins_taken, "R2", "reserved class",
        {cop_valid, illegal, ins_taken}, 3'b011);
    @(negedge clk); ins_valid = 1'b0; cop_ready = 1'b0;

    // R4: stray done while idle, with an exception
    ctl_exc_en = 1'b1; ctl_fe_mode = 2'b11;
    cop_done = 1'b1; cop_exc = 1'b1;
    @(negedge clk); cop_done = 1'b0; cop_exc = 1'b0;
    #1;
    chk(!wb_valid && !exc_report && !host_stall, "R4", "idle done ignored",
        {wb_valid, exc_report, host_stall}, 3'b0);

    // R4: one outstanding
    ctl_exc_en = 1'b0;
    @(negedge clk);
    ins_valid = 1'b1; ins_class = 2'b00; ins_opnd = 32'h11; cop_ready = 1'b1;
    @(negedge clk);
    ins_class = 2'b01; ins_dst = 5'd4; ins_opnd = 32'h22;
    #1;
    chk(!cop_valid && !ins_taken && host_stall, "R4", "second offer held",
        {cop_valid, ins_taken, host_stall}, 3'b001);
    @(negedge clk); cop_done = 1'b1;
    #1;
    chk(!cop_valid, "R4", "held in done cycle", cop_valid, 1'b0);
    @(negedge clk); cop_done = 1'b0;
    #1;
    chk(cop_valid && ins_taken && cop_data == 32'h22, "R4", "released after done",
        {cop_valid, ins_taken, cop_data}, {2'b11, 32'h22});
    @(negedge clk); ins_valid = 1'b0; cop_ready = 1'b0;
    #1;
    chk(host_stall, "R6", "blocking holds host", host_stall, 1'b1);
    @(negedge clk); cop_done = 1'b1; cop_result = 32'hCAFE; cop_ovf = 1'b1;
    @(negedge clk); cop_done = 1'b0;
    #1;
    chk(wb_valid && wb_data == 32'hCAFE && wb_reg == 5'd4 && wb_ovf && !host_stall, "R6",
        "write-back after release", {wb_valid, wb_ovf, wb_reg, wb_data}, {2'b11, 5'd4, 32'hCAFE});
    @(negedge clk); #1;
    chk(!wb_valid, "R6", "write-back one cycle", wb_valid, 1'b0);

    // R5 / R7 directed
    run_op(2'b00, 5'd3, 32'hA1, 32'h5, 1'b0, 1'b0, 3, 1, 1'b1, 5'd3);
    run_op(2'b10, 5'd9, 32'hB2, 32'h77, 1'b0, 1'b0, 2, 0, 1'b1, 5'd3);
    run_op(2'b10, 5'd9, 32'hB3, 32'h78, 1'b1, 1'b0, 2, 2, 1'b1, 5'd9);

    // R8 / R10: every mode, enable and presence setting
    for (int f = 0; f < 2; f++)
      for (int e = 0; e < 2; e++)
        for (int m = 0; m < 4; m++) begin
          ctl_fpu_here = f[0]; ctl_exc_en = e[0]; ctl_fe_mode = m[1:0];
          run_op(2'b00, 5'd1, 32'h1, 32'h0, 1'b0, 1'b1, 1, 0, 1'b0, 5'd0);
        end

    // R9: precise hold blocks dispatch in the report cycle
    ctl_fpu_here = 1'b1; ctl_exc_en = 1'b1; ctl_fe_mode = 2'b11;
    @(negedge clk); ins_valid = 1'b1; ins_class = 2'b00; cop_ready = 1'b1;
    @(negedge clk); ins_valid = 1'b0; cop_done = 1'b1; cop_exc = 1'b1;
    @(negedge clk); cop_done = 1'b0; cop_exc = 1'b0; ins_valid = 1'b1;
    #1;
    chk(exc_report && host_stall && !cop_valid, "R9", "report cycle blocks",
        {exc_report, host_stall, cop_valid}, 3'b110);
    @(negedge clk); #1;
    chk(cop_valid && ins_taken, "R9", "dispatch resumes", {cop_valid, ins_taken}, 2'b11);
    @(negedge clk); ins_valid = 1'b0; cop_ready = 1'b0; cop_done = 1'b1;
    @(negedge clk); cop_done = 1'b0;

    // Random mix
    for (int k = 0; k < 250; k++) begin
      logic [1:0]    c  = 2'($urandom % 3);
      logic [RW-1:0] d  = RW'($urandom);
      logic [RW-1:0] s  = ($urandom % 2) ? d : RW'($urandom);
      ctl_exc_en   = 1'($urandom);
      ctl_fpu_here = 1'($urandom);
      ctl_fe_mode  = 2'($urandom);
      run_op(c, d, $urandom, $urandom, 1'($urandom), 1'($urandom), int'($urandom % 5),
             int'($urandom % 3), 1'($urandom), s);
    end

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule